// File: doc/BRIEF.md
# Clause 22 PHY Management Access Controller

This block carries out one management transaction at a time towards an external Ethernet PHY, using the two-wire clause 22 serial protocol (MDC clock, bidirectional MDIO data). Software drives it through a single 32-bit command word. Bit 31 is a request flag: software sets it to start a transaction, and the block clears it when the frame has gone out. Read data comes back in the low half of the same word. Software therefore writes once and then polls the word until bit 31 reads zero. Two PHYs, at addresses 5 and 6, serve the two ports. A typical first access writes 0x9000 to register 0, which issues a PHY soft reset (data bit 15) and turns on auto-negotiation (data bit 12).

The MDC clock is the system clock divided by the even parameter `DIV`. MDC stays low while no transaction is in flight. The block shifts out a 64-bit frame, and MDIO changes only when MDC falls. For a read, the block stops driving MDIO at the turnaround. It then samples the PHY's reply on each rising edge of MDC.

Top module: `mdio_access_ctrl`

## Requirements
- R1: After reset the command word reads 0x00000000, MDC is low and MDIO is not driven (`mdio_oe` = 0).
- R2: A write of the command word while bit 31 is clear stores the value. If the stored bit 31 is 1, this starts a transaction, and the word reads back unchanged (bit 31 still set) until completion. Field layout: bit 31 request, bit 30 direction (1 = write, 0 = read), bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data.
- R3: Every frame begins with 32 ones, then start bits 0,1, then opcode 0,1 for a write or 1,0 for a read. These are followed by the PHY address and then the register address, each most significant bit first.
- R4: A write frame continues with turnaround bits 1,0 and the 16 data bits, MSB first. MDIO is driven for all 64 bit times.
- R5: A read frame releases MDIO for the last 18 bit times (turnaround and data). It captures 16 bits from `mdio_i`, MSB first, on the rising MDC edges of bit times 49 to 64.
- R6: MDC has a period of `DIV` system clocks with equal high and low phases. It is held low whenever no transaction is in flight. MDIO output changes only on a clock edge where MDC falls.
- R7: Bit 31 clears on the clock edge of the 64th falling MDC edge, exactly 64*DIV clocks after the accepting edge. On a read, bits 15:0 take the captured value in that same cycle. All other bits keep their written values.
- R8: Writes to the command word while bit 31 is set are ignored. This includes a write in the very cycle the transaction completes.
- R9: A write with bit 31 clear stores the value without starting a transaction. MDC stays low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr_en | input | 1 | Write strobe for the command word |
| acc_wr_data | input | 32 | Value to write into the command word |
| acc_rd_data | output | 32 | Current command word (request flag, fields, read data) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
Completion of a transaction and a software write of the command word can land on the same clock edge. In that case the write must lose, because the request bit is still set during the completion cycle. The bench counts 64*DIV-1 edges after the accepting edge and checks that bit 31 is still set. It then presents a different command exactly on the completion edge. Afterwards the word must hold the finished transaction's value with bit 31 clear, and MDC must stay low, showing that no second frame started.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ACC_W      = 32;
  localparam int REQ_BIT    = 31;
  localparam int DIR_BIT    = 30;
  localparam int PHY_HI     = 25;
  localparam int PHY_LO     = 21;
  localparam int REG_HI     = 20;
  localparam int REG_LO     = 16;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int REL_FIRST  = 46;  // first bit time (0-based) released on a read
  localparam int DAT_FIRST  = 48;  // first data bit time (0-based)

  typedef struct packed {
    logic              is_wr;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 8  // even, at least 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] hc_q;
  logic          mdc_q;
  logic          term;

  assign term     = en && (hc_q == HW'(HALF - 1));
  assign rise_stb = term && !mdc_q;
  assign fall_stb = term && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hc_q  <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      hc_q  <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      hc_q  <= hc_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int CW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame_q;
  logic [CW-1:0]         bit_q;
  logic [DATA_W-1:0]     rdsh_q;
  logic                  active_q, is_rd_q, oe_q;
  logic                  last_bit;
  logic [CW-1:0]         bit_nx;

  assign last_bit = (bit_q == CW'(FRAME_BITS - 1));
  assign bit_nx   = bit_q + 1'b1;
  assign done     = active_q && fall_stb && last_bit;
  assign active   = active_q;
  assign rd_data  = rdsh_q;
  assign mdio_o   = frame_q[FRAME_BITS-1];
  assign mdio_oe  = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q  <= '0;
      bit_q    <= '0;
      rdsh_q   <= '0;
      active_q <= 1'b0;
      is_rd_q  <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start && !active_q) begin
      frame_q  <= {{PRE_BITS{1'b1}}, 2'b01, (cmd.is_wr ? 2'b01 : 2'b10),
                   cmd.phy, cmd.regad, 2'b10, cmd.data};
      bit_q    <= '0;
      active_q <= 1'b1;
      is_rd_q  <= !cmd.is_wr;
      oe_q     <= 1'b1;
    end else if (active_q) begin
      if (rise_stb && is_rd_q && (bit_q >= CW'(DAT_FIRST)))
        rdsh_q <= {rdsh_q[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (last_bit) begin
          active_q <= 1'b0;
          oe_q     <= 1'b0;
        end else begin
          bit_q   <= bit_nx;
          frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
          oe_q    <= !(is_rd_q && (bit_nx >= CW'(REL_FIRST)));
        end
      end
    end
  end

  // R6: within a transaction MDIO only moves together with a falling MDC
  p_mdio_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (active_q && $past(active_q) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));
  // R5: nothing is driven once a frame has ended
  p_release_after_done_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !mdio_oe);
endmodule

// File: rtl/mdio_access_ctrl.sv
module mdio_access_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_wr_en,
  input  logic [31:0] acc_wr_data,
  output logic [31:0] acc_rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [ACC_W-1:0]  acc_q;
  logic              wr_ok, start, active, done;
  logic              rise_stb, fall_stb;
  logic [DATA_W-1:0] rd_data;
  mdio_cmd_t         cmd;

  assign wr_ok       = acc_wr_en && !acc_q[REQ_BIT];
  assign start       = wr_ok && acc_wr_data[REQ_BIT];
  assign cmd.is_wr   = acc_wr_data[DIR_BIT];
  assign cmd.phy     = acc_wr_data[PHY_HI:PHY_LO];
  assign cmd.regad   = acc_wr_data[REG_HI:REG_LO];
  assign cmd.data    = acc_wr_data[DATA_W-1:0];
  assign acc_rd_data = acc_q;

  mdio_clk_div #(.DIV(DIV)) clk_div_i (
    .clk(clk), .rst(rst), .en(active),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine engine_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdc(mdc), .mdio_i(mdio_i),
    .active(active), .done(done), .rd_data(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (wr_ok) begin
      acc_q <= acc_wr_data;
    end else if (done) begin
      acc_q[REQ_BIT] <= 1'b0;
      if (!acc_q[DIR_BIT]) acc_q[DATA_W-1:0] <= rd_data;
    end
  end

  // R2: the request flag tracks the frame engine exactly
  p_req_tracks_engine_r2: assert property (@(posedge clk) disable iff (rst)
    acc_q[REQ_BIT] == active);
  // R7: completion clears the request flag on the next edge
  p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !acc_q[REQ_BIT]);
  // R7: completion coincides with the end of an MDC high phase
  p_done_mdc_high_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> mdc);
  // R8: a busy word only changes through completion
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_q[REQ_BIT] && !done) |=> (acc_q == $past(acc_q)));
  // R6: MDC rests low while idle
  p_idle_mdc_low_r6: assert property (@(posedge clk) disable iff (rst)
    !acc_q[REQ_BIT] |-> !mdc);
endmodule

// File: tb/mdio_access_ctrl_tb.sv
module mdio_access_ctrl_tb_top;
  localparam int DIV = 8;

  typedef struct {
    logic [63:0] frame;
    logic [63:0] oe;
    logic [31:0] word;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_wr_en = 1'b0;
  logic [31:0] acc_wr_data = '0;
  logic [31:0] acc_rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_rise_cyc = 0;
  int period = 0;
  int rises = 0;
  logic [63:0] cap_f = '0;
  logic [63:0] cap_oe = '0;
  logic [63:0] phy_word = '0;
  logic        prev_req = 1'b0;
  exp_t        q[$];

  always #10 clk = ~clk;  // 50 MHz

  mdio_access_ctrl #(.DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
    .acc_rd_data(acc_rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // PHY side: record what the block drives, answer reads after turnaround
  always @(posedge mdc) begin
    cap_f  = {cap_f[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    if (rises > 0) period = cyc - last_rise_cyc;
    last_rise_cyc = cyc;
    rises++;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises < 64) mdio_i = phy_word[63-rises];
    else mdio_i = 1'b1;
  end

  // Monitor: on each completion compare against the scoreboard head
  always @(negedge clk) begin
    if (!rst && prev_req && !acc_rd_data[31]) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7 unexpected completion", 64'(acc_rd_data), 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk((cap_f & e.oe) == (e.frame & e.oe), "R3/R4 frame bits",
            cap_f & e.oe, e.frame & e.oe);
        chk(cap_oe == e.oe, "R4/R5 drive pattern", cap_oe, e.oe);
        chk(acc_rd_data == e.word, "R7 final word", 64'(acc_rd_data), 64'(e.word));
        chk(rises == 64, "R6 MDC rising edges", 64'(rises), 64'd64);
      end
    end
    prev_req = acc_rd_data[31];
  end

  task automatic issue(input logic [31:0] v, input logic [15:0] phy_val);
    exp_t e;
    logic wr;
    wr = v[30];
    e.frame = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), v[25:21], v[20:16],
               (wr ? {2'b10, v[15:0]} : 18'h0)};
    e.oe    = wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'h0};
    e.word  = wr ? {1'b0, v[30:0]} : {1'b0, v[30:16], phy_val};
    @(negedge clk);
    phy_word = {48'h0, phy_val};
    rises = 0; cap_f = '0; cap_oe = '0;
    q.push_back(e);
    acc_wr_en = 1'b1; acc_wr_data = v;
    @(posedge clk);
    @(negedge clk);
    acc_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (acc_rd_data[31]) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(acc_rd_data == 32'h0, "R1 word after reset", 64'(acc_rd_data), 64'h0);
    chk(mdc == 1'b0, "R1 mdc after reset", 64'(mdc), 64'h0);
    chk(mdio_oe == 1'b0, "R1 mdio_oe after reset", 64'(mdio_oe), 64'h0);

    // R2/R3/R4: reset + autoneg write to PHY 5 register 0
    issue(32'hC0A0_9000, 16'h0);
    chk(acc_rd_data == 32'hC0A0_9000, "R2 word held while busy",
        64'(acc_rd_data), 64'hC0A0_9000);
    wait_idle();
    chk(period == DIV, "R6 MDC period", 64'(period), 64'(DIV));

    // Same for PHY 6
    issue(32'hC0C0_9000, 16'h0);
    wait_idle();

    // R8: write during the frame is ignored
    issue(32'hC0C1_1234, 16'h0);
    repeat (100) @(negedge clk);
    acc_wr_en = 1'b1; acc_wr_data = 32'hC0A0_FFFF;
    @(negedge clk);
    acc_wr_en = 1'b0;
    chk(acc_rd_data == 32'hC0C1_1234, "R8 busy write ignored",
        64'(acc_rd_data), 64'hC0C1_1234);
    wait_idle();

    // R5: reads with assorted reply patterns
    issue(32'h80C1_0000, 16'hA5C3);
    wait_idle();
    issue(32'h80A2_FFFF, 16'h8001);
    wait_idle();
    issue(32'h80BF_0000, 16'h7FFE);
    wait_idle();

    // R7/R8: write lands on the completion edge
    issue(32'hC0A0_5555, 16'h0);
    repeat (64*DIV-1) @(posedge clk);
    @(negedge clk);
    chk(acc_rd_data[31] == 1'b1, "R7 still busy one cycle before end",
        64'(acc_rd_data[31]), 64'h1);
    acc_wr_en = 1'b1; acc_wr_data = 32'hC0C0_AAAA;
    @(negedge clk);
    acc_wr_en = 1'b0;
    chk(acc_rd_data == 32'h40A0_5555, "R8 write at completion ignored",
        64'(acc_rd_data), 64'h40A0_5555);
    begin
      int r0;
      r0 = rises;
      repeat (3*DIV) @(negedge clk);
      chk(rises == r0 && !mdc, "R8 no new frame after collision",
          64'(rises), 64'(r0));
    end

    // R9: no request bit, no transaction
    begin
      int r0;
      r0 = rises;
      @(negedge clk);
      acc_wr_en = 1'b1; acc_wr_data = 32'h00A0_1111;
      @(negedge clk);
      acc_wr_en = 1'b0;
      chk(acc_rd_data == 32'h00A0_1111, "R9 word stored", 64'(acc_rd_data),
          64'h00A0_1111);
      repeat (200) @(negedge clk);
      chk(rises == r0 && !mdc && !mdio_oe, "R9 bus stays idle",
          64'(rises), 64'(r0));
    end

    chk(q.size() == 0, "R7 all transactions completed", 64'(q.size()), 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule